// File: doc/BRIEF.md
# Selectable-Timebase 16-bit Counter with Coherent Byte Read

This block is a free-running 16-bit up-counter that a processor reads and controls through a small byte-wide register port. The pace of counting is chosen by a 3-bit timebase code. The choices are two fixed divisions of the system clock, the system clock itself, an overflow strobe from a neighbouring timer, and falling edges of an external pin. The last two choices are an external oscillator and a low-frequency oscillator, each divided by eight. Sources that are not in step with the system clock pass through a two-flop synchroniser before they can enable a count. Counting advances by exactly one on each single-cycle enable pulse.

The counter is read as two bytes. Reading the low byte freezes the current high byte into a snapshot register, and a later read of the high byte returns that frozen value. A low-then-high read pair therefore yields a coherent 16-bit value while the counter keeps running. A sticky overflow flag records each wrap from all-ones to zero. It drives an interrupt request when enabled. A mode bit can halt counting while the processor reports idle.

Top module: `tbsel_counter`

## Requirements
- R1: After reset the count, snapshot, mode byte, overflow flag and read data are all zero and `irq_o` is 0.
- R2: Address 0 reads the count low byte, address 1 the snapshot, address 2 the mode byte {idle_halt[7], run[6], zero[5:4], timebase[3:1], irq_enable[0]} (bits 5:4 read as 0), and address 3 the flag in bit 0. Read data is valid in the cycle after `bus_rd_i`. Writes to addresses 0 and 1 have no effect.
- R3: A read of address 0 copies the count's high byte into the snapshot in the same cycle. A read of address 1 returns the snapshot, not the live high byte.
- R4: Reads never stall or change the count. A low-then-high pair returns the count as it stood at the low read.
- R5: Timebase 100 advances the count once per system clock. No count advances while run is 0.
- R6: Timebase 000 advances once every 12 system clocks and timebase 001 once every 4, both from free-running prescalers.
- R7: Timebase 010 advances once per cycle that `tmr_ovf_i` is high.
- R8: Timebase 011 advances once per high-to-low transition of `ext_cnt_i` after a two-flop synchroniser. Rising transitions do not count. The pin is counted reliably at up to a quarter of the system clock rate.
- R9: Timebases 101 and 110 advance once per eight rising edges of `xosc_i` and of `lfo_i` respectively, after synchronisation.
- R10: Timebase 111 never advances the count.
- R11: A count step from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until a write of 0 to bit 0 of address 3. A write of 1 there has no effect.
- R12: When a flag-clear write and a wrap happen in the same cycle, the flag ends set.
- R13: `irq_o` is high exactly while the flag is set and irq_enable is 1.
- R14: With idle_halt set, no count advances while `cpu_idle_i` is high. With idle_halt clear, idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_idle_i | input | 1 | Processor idle indication |
| tmr_ovf_i | input | 1 | One-cycle overflow strobe from another timer |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| xosc_i | input | 1 | External oscillator waveform, asynchronous |
| lfo_i | input | 1 | Low-frequency oscillator waveform, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A mode write sampled at edge k changes what counts from edge k+1. The count registered at edge k+N therefore reflects exactly N enabled cycles. The bench opens and closes each counting window with writes a known number of edges apart, and predicts the count difference from the timebase. For the prescaled timebases it uses window lengths that are whole multiples of the prescale period. Read data appears one edge after the read strobe and is sampled at the following falling edge. The expected value of a running count is taken from a bench cycle counter that records the edge at which counting started and the edge at which the low byte was read. The synchronised inputs need about three edges to take effect, so the bench drains them for several cycles before it closes a window. To test set-over-clear priority, the flag-clear write is placed on the exact edge at which a wrap is computed to occur.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        TB_SYS_DIV12 = 3'b000,
        TB_SYS_DIV4  = 3'b001,
        TB_NEIGHBOUR = 3'b010,
        TB_PIN_FALL  = 3'b011,
        TB_SYS_FULL  = 3'b100,
        TB_XOSC_DIV  = 3'b101,
        TB_LFO_DIV   = 3'b110,
        TB_NONE      = 3'b111
    } tbase_e;

    typedef enum logic [1:0] {
        RA_CNT_LO = 2'd0,
        RA_SNAP   = 2'd1,
        RA_MODE   = 2'd2,
        RA_FLAG   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       idle_halt;
        logic       run;
        logic [1:0] zero;
        logic [2:0] tbase;
        logic       irq_en;
    } mode_t;
endpackage

// File: rtl/tbsel_prescale.sv
module tbsel_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q == LAST);

    assert_div_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    generate
        if (DIV > 1) begin : g_gap
            assert_div_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_o |=> !pulse_o);
        end
    endgenerate
endmodule

// File: rtl/tbsel_edge_sync.sv
module tbsel_edge_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  settled;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign settled = s_q.chain[STAGES-1];

    generate
        if (FALLING) begin : g_fall
            assign edge_o = s_q.prev & ~settled;
        end else begin : g_rise
            assign edge_o = ~s_q.prev & settled;
        end
    endgenerate

    assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/tbsel_osc_div.sv
module tbsel_osc_div #(
    parameter int STAGES = 2,
    parameter int DIV    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic pulse_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic          rise;
    logic [CW-1:0] cnt_d, cnt_q;

    tbsel_edge_sync #(.STAGES(STAGES), .FALLING(1'b0)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (osc_i),
        .edge_o (rise)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (rise) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = rise && (cnt_q == LAST);

    assert_osc_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    assert_osc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(cnt_q));
endmodule

// File: rtl/tbsel_counter.sv
module tbsel_counter
    import tbsel_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int OSC_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_idle_i,
    input  logic              tmr_ovf_i,
    input  logic              ext_cnt_i,
    input  logic              xosc_i,
    input  logic              lfo_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [BYTE_W-1:0] snap;
        mode_t             mode;
        logic              flag;
        logic [BYTE_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;
    logic   p_slow, p_fast, p_pin, p_xosc, p_lfo;
    logic   src, enable, tick, wrap, flag_clr;

    tbsel_prescale #(.DIV(DIV_SLOW)) u_pre_slow (.clk(clk), .rst_n(rst_n), .pulse_o(p_slow));
    tbsel_prescale #(.DIV(DIV_FAST)) u_pre_fast (.clk(clk), .rst_n(rst_n), .pulse_o(p_fast));

    tbsel_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_pin (
        .clk(clk), .rst_n(rst_n), .din(ext_cnt_i), .edge_o(p_pin));

    tbsel_osc_div #(.STAGES(SYNC_STAGES), .DIV(OSC_DIV)) u_xosc (
        .clk(clk), .rst_n(rst_n), .osc_i(xosc_i), .pulse_o(p_xosc));
    tbsel_osc_div #(.STAGES(SYNC_STAGES), .DIV(OSC_DIV)) u_lfo (
        .clk(clk), .rst_n(rst_n), .osc_i(lfo_i), .pulse_o(p_lfo));

    always_comb begin
        unique case (tbase_e'(s_q.mode.tbase))
            TB_SYS_DIV12: src = p_slow;
            TB_SYS_DIV4:  src = p_fast;
            TB_NEIGHBOUR: src = tmr_ovf_i;
            TB_PIN_FALL:  src = p_pin;
            TB_SYS_FULL:  src = 1'b1;
            TB_XOSC_DIV:  src = p_xosc;
            TB_LFO_DIV:   src = p_lfo;
            default:      src = 1'b0;
        endcase
        enable   = s_q.mode.run && !(s_q.mode.idle_halt && cpu_idle_i);
        tick     = enable && src;
        wrap     = tick && (s_q.count == {CNT_W{1'b1}});
        flag_clr = bus_wr_i && (reg_addr_e'(bus_addr_i) == RA_FLAG) && !bus_wdata_i[0];
    end

    always_comb begin
        s_d = s_q;
        if (tick) s_d.count = s_q.count + 1'b1;

        if (bus_wr_i && (reg_addr_e'(bus_addr_i) == RA_MODE)) begin
            s_d.mode      = mode_t'(bus_wdata_i);
            s_d.mode.zero = 2'b00;
        end

        if (flag_clr) s_d.flag = 1'b0;
        if (wrap)     s_d.flag = 1'b1;

        if (bus_rd_i) begin
            unique case (reg_addr_e'(bus_addr_i))
                RA_CNT_LO: begin
                    s_d.rdata = s_q.count[BYTE_W-1:0];
                    s_d.snap  = s_q.count[CNT_W-1:BYTE_W];
                end
                RA_SNAP:   s_d.rdata = s_q.snap;
                RA_MODE:   s_d.rdata = s_q.mode;
                default:   s_d.rdata = {{(BYTE_W-1){1'b0}}, s_q.flag};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata_o = s_q.rdata;
    assign irq_o       = s_q.flag && s_q.mode.irq_en;

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> s_q.count == $past(s_q.count) + 1'b1);
    assert_norun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.mode.run |=> $stable(s_q.count));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.count));
    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode.tbase == 3'b111) |=> $stable(s_q.count));
    assert_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode.idle_halt && cpu_idle_i) |=> $stable(s_q.count));
    assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == {CNT_W{1'b1}} && tick) |=> (s_q.flag && s_q.count == '0));
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !flag_clr) |=> s_q.flag);
    assert_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 2'd0) |=> s_q.snap == $past(s_q.count[CNT_W-1:BYTE_W]));
    assert_irq_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.flag |-> !irq_o);
endmodule

// File: tb/tb_tbsel_counter.sv
`timescale 1ns/1ps
module tb_tbsel_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_idle_i = 1'b0, tmr_ovf_i = 1'b0, ext_cnt_i = 1'b0;
    logic       xosc_i = 1'b0, lfo_i = 1'b0;
    logic       bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic [7:0] bus_wdata_i = 8'd0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tbsel_counter dut (.*);

    function automatic logic [7:0] md(input bit ih, input bit run, input logic [2:0] tb, input bit ie);
        return {ih, run, 2'b00, tb, ie};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks enter and leave at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v, output int at);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        v = bus_rdata_o; at = cyc;
        bus_rd_i = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi; int t;
        rd(2'd0, lo, t);
        rd(2'd1, hi, t);
        v = {hi, lo};
    endtask

    // count for exactly n enabled edges with mode m (run forced on), then stop
    task automatic window(input logic [7:0] m, input int n);
        wr(2'd2, m | 8'h40);
        repeat (n - 1) @(negedge clk);
        wr(2'd2, m & 8'hBF);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v; int t, c0, c1, s, r, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v, t);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", irq_o, 0);

        // R2 mode readback with zero bits, R10 reserved timebase holds count
        wr(2'd2, 8'hFF);
        rd(2'd2, v, t);
        chk("R2 mode readback", v, 8'hCF);
        wr(2'd0, 8'h5A); wr(2'd1, 8'hA5);
        repeat (40) @(negedge clk);
        rd16(c0);
        chk("R10 reserved timebase / R2 count writes ignored", c0, 0);
        wr(2'd2, 8'h00);

        // R5 no run, then every cycle
        wr(2'd2, md(0, 0, 3'b100, 0));
        repeat (20) @(negedge clk);
        rd16(c0);
        chk("R5 run clear holds", c0, 0);
        window(md(0, 0, 3'b100, 0), 100);
        rd16(c1);
        chk("R5 every clock", c1 - c0, 100);

        // R6 prescalers
        c0 = c1;
        window(md(0, 0, 3'b000, 0), 1200);
        rd16(c1);
        chk("R6 divide by 12", c1 - c0, 100);
        c0 = c1;
        window(md(0, 0, 3'b001, 0), 400);
        rd16(c1);
        chk("R6 divide by 4", c1 - c0, 100);

        // R7 neighbour overflow strobe
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b010, 0));
        for (int i = 0; i < 10; i++) begin
            tmr_ovf_i = 1'b1;
            @(negedge clk);
            tmr_ovf_i = 1'b0;
            repeat (i % 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        wr(2'd2, md(0, 0, 3'b010, 0));
        rd16(c1);
        chk("R7 neighbour strobes", c1 - c0, 10);

        // R8 external pin falling edges at quarter rate
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b011, 0));
        for (int i = 0; i < 12; i++) begin
            ext_cnt_i = 1'b1; repeat (2) @(negedge clk);
            ext_cnt_i = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd16(c1);
        chk("R8 falling edges counted", c1 - c0, 12);
        ext_cnt_i = 1'b1;
        repeat (8) @(negedge clk);
        rd16(c1);
        chk("R8 rising edge ignored", c1 - c0, 12);
        wr(2'd2, md(0, 0, 3'b011, 0));
        ext_cnt_i = 1'b0;
        repeat (6) @(negedge clk);

        // R9 oscillator sources divided by eight
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b101, 0));
        for (int i = 0; i < 24; i++) begin
            xosc_i = 1'b1; repeat (5) @(negedge clk);
            xosc_i = 1'b0; repeat (5) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(2'd2, md(0, 0, 3'b101, 0));
        rd16(c1);
        chk("R9 external oscillator /8", c1 - c0, 3);
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b110, 0));
        for (int i = 0; i < 16; i++) begin
            lfo_i = 1'b1; repeat (7) @(negedge clk);
            lfo_i = 1'b0; repeat (7) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(2'd2, md(0, 0, 3'b110, 0));
        rd16(c1);
        chk("R9 low-frequency oscillator /8", c1 - c0, 2);

        // R3 / R4 snapshot while running
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b100, 0));
        s = cyc;
        repeat (37) @(negedge clk);
        rd(2'd0, v, r);
        chk("R4 live low byte", v, (c0 + r - s - 1) & 8'hFF);
        repeat (600) @(negedge clk);
        rd(2'd1, v, t);
        chk("R3 high byte from snapshot", v, ((c0 + r - s - 1) >> 8) & 8'hFF);
        wr(2'd2, md(0, 0, 3'b100, 0));
        t = cyc;
        rd16(c1);
        chk("R4 reads did not disturb count", c1, (c0 + t - s) & 16'hFFFF);

        // R14 idle gating
        c0 = c1;
        cpu_idle_i = 1'b1;
        window(md(1, 0, 3'b100, 0), 50);
        rd16(c1);
        chk("R14 idle halts", c1 - c0, 0);
        window(md(0, 0, 3'b100, 0), 50);
        rd16(c1);
        chk("R14 idle ignored when halt clear", c1 - c0, 50);
        cpu_idle_i = 1'b0;

        // R11 / R12 / R13 overflow, clear collides with wrap
        c0 = c1;
        wr(2'd2, md(0, 1, 3'b100, 0));
        k = 16'hFFFF - c0;
        repeat (k) @(negedge clk);
        wr(2'd3, 8'h00);
        wr(2'd2, md(0, 0, 3'b100, 0));
        rd16(c1);
        chk("R11 wrap to zero then one step", c1, 1);
        repeat (20) @(negedge clk);
        rd(2'd3, v, t);
        chk("R12 set wins over clear", v, 1);
        chk("R13 irq low when disabled", irq_o, 0);
        wr(2'd2, md(0, 0, 3'b100, 1));
        chk("R13 irq high when enabled", irq_o, 1);
        wr(2'd3, 8'h01);
        rd(2'd3, v, t);
        chk("R11 write one ignored", v, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v, t);
        chk("R11 write zero clears", v, 0);
        chk("R13 irq drops with flag", irq_o, 0);

        finish_run();
    end
endmodule